// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits beside a processor that reports each bus transfer only as a three-bit status code. It watches for the status leaving its passive code and then runs the transfer's phases (T1, T2, T3, any wait states, T4) on its own. From those phases it produces the address-latch strobe, the transceiver enable and direction, and separate read and write command strobes for memory and IO space. Two write timings are provided: an early strobe from T2 and a normal strobe from T3. It also produces an interrupt-acknowledge strobe and one dual-purpose enable pin.

The status code is captured when the cycle starts. After that the processor may return its status to passive during T3 and T4, and the command timing does not change. A ready input stretches the command phase with wait states. Three strap-style inputs shape the outputs. One releases the bus and silences all commands. One disables the transceiver enable and all commands. One picks the meaning of the dual-purpose pin: a cascade enable for an interrupt controller, or a peripheral data enable.

All strobes are active high. The direction output is high when the processor transmits.

Top module: `bcmd_gen`

## Requirements
- R1: While reset is low and right after it, all strobes and commands and the dual-purpose pin are low, and the direction output is high.
- R2: A cycle starts at a rising edge where the status sampled at the previous edge was 111 and the present status is neither 111 nor 011. The address strobe is then high for exactly the next clock (T1). A status held steady at a non-passive code starts no further cycle.
- R3: Status 011 (halt) starts no cycle. No strobe is raised.
- R4: For status 101 (memory read) or 100 (fetch), the memory read command and the transceiver enable are high from T2 through the last T3 or wait state. For 001 (IO read), the IO read command behaves the same way. For every inbound code (000, 001, 100, 101), the direction output is low from T1 through T4.
- R5: For status 110 (memory write) or 010 (IO write), the early write strobe of that space is high from T2 and the normal write strobe from T3. Both stay high through the last T3 or wait state. The direction output stays high.
- R6: Ready is sampled at the edge that ends T3 and at the edge that ends each wait state. A low value adds a wait state in which every active strobe is held.
- R7: Status returning to 111 during T2 or T3 does not change the running cycle.
- R8: For status 000 (interrupt acknowledge), the acknowledge strobe is high from T2 through the last T3 or wait state. Two such cycles give two separate pulses.
- R9: With the mode input low, the dual-purpose pin is high only in T1 of an interrupt acknowledge cycle. With it high, the pin equals the transceiver enable.
- R10: With the bus-release input high, all command and acknowledge strobes are low. The address strobe, the transceiver enable and the direction output keep their timing.
- R11: With the command-enable input low, the transceiver enable and all command and acknowledge strobes are low.
- R12: A status that leaves 111 during T4 starts the next cycle at the edge that ends T4, with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_i | input | 3 | Processor status code |
| rdy_i | input | 1 | Transfer ready, sampled at the end of T3 and of each wait state |
| bus_off_i | input | 1 | High releases the bus: commands forced low |
| cmd_ena_i | input | 1 | Low disables the transceiver enable and all commands |
| sys_bus_i | input | 1 | Selects the meaning of the dual-purpose pin |
| ale_o | output | 1 | Address latch strobe (T1) |
| den_o | output | 1 | Transceiver enable |
| dir_tx_o | output | 1 | Transceiver direction, high = processor transmits |
| mem_rd_o | output | 1 | Memory read command |
| mem_wr_o | output | 1 | Memory write command (from T3) |
| mem_wr_adv_o | output | 1 | Early memory write command (from T2) |
| io_rd_o | output | 1 | IO read command |
| io_wr_o | output | 1 | IO write command (from T3) |
| io_wr_adv_o | output | 1 | Early IO write command (from T2) |
| int_ack_o | output | 1 | Interrupt acknowledge strobe |
| mce_pden_o | output | 1 | Cascade enable or peripheral data enable |

## Verification
Every non-passive code is driven through a full cycle, and the complete output word is compared in each phase. This separates read from write and memory from IO, and it separates the early write strobe from the normal one at T2. Ready held low for zero, one or two edges shows that wait states hold the strobes and that the normal write starts only at T3. Status held steady, the halt code, and a status change during T4 separate a real passive-to-active transition from a mere non-passive level. Two acknowledge cycles back to back show that the pulses do not merge. Runs with the bus-release input, the command-enable input and each mode of the dual-purpose pin show which outputs each of them gates.

// File: rtl/bcmd_pkg.sv
package bcmd_pkg;

  localparam int STW = 3;

  typedef enum logic [STW-1:0] {
    ST_INTA  = 3'd0,
    ST_IORD  = 3'd1,
    ST_IOWR  = 3'd2,
    ST_HALT  = 3'd3,
    ST_FETCH = 3'd4,
    ST_MRD   = 3'd5,
    ST_MWR   = 3'd6,
    ST_PASS  = 3'd7
  } stat_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  typedef struct packed {
    logic mrd;
    logic mwr;
    logic amwr;
    logic iord;
    logic iowr;
    logic aiowr;
    logic inta;
  } cmd_t;

  function automatic logic opens_cycle(stat_e s);
    return (s != ST_PASS) && (s != ST_HALT);
  endfunction

  function automatic logic is_inbound(stat_e s);
    return (s == ST_INTA) || (s == ST_IORD) || (s == ST_FETCH) || (s == ST_MRD);
  endfunction

  function automatic logic is_mem_read(stat_e s);
    return (s == ST_FETCH) || (s == ST_MRD);
  endfunction

  function automatic logic in_cycle(phase_e p);
    return p != PH_IDLE;
  endfunction

  function automatic logic cmd_window(phase_e p);
    return (p == PH_T2) || (p == PH_T3) || (p == PH_TW);
  endfunction

  function automatic logic late_window(phase_e p);
    return (p == PH_T3) || (p == PH_TW);
  endfunction

endpackage

// File: rtl/bcmd_phase.sv
module bcmd_phase
  import bcmd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [STW-1:0] stat_i,
  input  logic           rdy_i,
  output phase_e         phase_o,
  output stat_e          kind_o,
  output logic           start_o
);

  stat_e  stat_now;
  stat_e  stat_q;
  phase_e phase_q;
  phase_e phase_d;
  stat_e  kind_q;
  logic   may_open;

  assign stat_now = stat_e'(stat_i);
  assign may_open = (phase_q == PH_IDLE) || (phase_q == PH_T4);
  assign start_o  = may_open && (stat_q == ST_PASS) && opens_cycle(stat_now);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: phase_d = start_o ? PH_T1 : PH_IDLE;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = rdy_i ? PH_T4 : PH_TW;
      PH_TW:   phase_d = rdy_i ? PH_T4 : PH_TW;
      PH_T4:   phase_d = start_o ? PH_T1 : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= ST_PASS;
      phase_q <= PH_IDLE;
      kind_q  <= ST_PASS;
    end else begin
      stat_q  <= stat_now;
      phase_q <= phase_d;
      if (start_o) kind_q <= stat_now;
    end
  end

  assign phase_o = phase_q;
  assign kind_o  = kind_q;

endmodule

// File: rtl/bcmd_decode.sv
module bcmd_decode
  import bcmd_pkg::*;
(
  input  phase_e phase_i,
  input  stat_e  kind_i,
  output cmd_t   cmd_raw_o,
  output logic   ale_o,
  output logic   den_raw_o,
  output logic   dir_tx_o,
  output logic   cascade_o
);

  logic win;
  logic late;

  assign win  = cmd_window(phase_i);
  assign late = late_window(phase_i);

  always_comb begin
    cmd_raw_o       = '0;
    cmd_raw_o.mrd   = win  && is_mem_read(kind_i);
    cmd_raw_o.amwr  = win  && (kind_i == ST_MWR);
    cmd_raw_o.mwr   = late && (kind_i == ST_MWR);
    cmd_raw_o.iord  = win  && (kind_i == ST_IORD);
    cmd_raw_o.aiowr = win  && (kind_i == ST_IOWR);
    cmd_raw_o.iowr  = late && (kind_i == ST_IOWR);
    cmd_raw_o.inta  = win  && (kind_i == ST_INTA);
  end

  assign ale_o     = (phase_i == PH_T1);
  assign den_raw_o = win;
  assign dir_tx_o  = !(in_cycle(phase_i) && is_inbound(kind_i));
  assign cascade_o = (phase_i == PH_T1) && (kind_i == ST_INTA);

endmodule

// File: rtl/bcmd_gate.sv
module bcmd_gate
  import bcmd_pkg::*;
(
  input  cmd_t cmd_raw_i,
  input  logic den_raw_i,
  input  logic cascade_i,
  input  logic bus_off_i,
  input  logic cmd_ena_i,
  input  logic sys_bus_i,
  output cmd_t cmd_o,
  output logic den_o,
  output logic mce_pden_o
);

  logic cmd_allow;

  assign cmd_allow  = cmd_ena_i && !bus_off_i;
  assign cmd_o      = cmd_allow ? cmd_raw_i : '0;
  assign den_o      = den_raw_i && cmd_ena_i;
  assign mce_pden_o = sys_bus_i ? den_o : cascade_i;

endmodule

// File: rtl/bcmd_gen.sv
module bcmd_gen
  import bcmd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [STW-1:0] stat_i,
  input  logic           rdy_i,
  input  logic           bus_off_i,
  input  logic           cmd_ena_i,
  input  logic           sys_bus_i,
  output logic           ale_o,
  output logic           den_o,
  output logic           dir_tx_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic           mem_wr_adv_o,
  output logic           io_rd_o,
  output logic           io_wr_o,
  output logic           io_wr_adv_o,
  output logic           int_ack_o,
  output logic           mce_pden_o
);

  phase_e phase_w;
  stat_e  kind_w;
  logic   cyc_start_w;
  cmd_t   cmd_raw_w;
  cmd_t   cmd_w;
  logic   den_raw_w;
  logic   cascade_w;

  bcmd_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_i  (stat_i),
    .rdy_i   (rdy_i),
    .phase_o (phase_w),
    .kind_o  (kind_w),
    .start_o (cyc_start_w)
  );

  bcmd_decode u_decode (
    .phase_i   (phase_w),
    .kind_i    (kind_w),
    .cmd_raw_o (cmd_raw_w),
    .ale_o     (ale_o),
    .den_raw_o (den_raw_w),
    .dir_tx_o  (dir_tx_o),
    .cascade_o (cascade_w)
  );

  bcmd_gate u_gate (
    .cmd_raw_i  (cmd_raw_w),
    .den_raw_i  (den_raw_w),
    .cascade_i  (cascade_w),
    .bus_off_i  (bus_off_i),
    .cmd_ena_i  (cmd_ena_i),
    .sys_bus_i  (sys_bus_i),
    .cmd_o      (cmd_w),
    .den_o      (den_o),
    .mce_pden_o (mce_pden_o)
  );

  assign mem_rd_o     = cmd_w.mrd;
  assign mem_wr_o     = cmd_w.mwr;
  assign mem_wr_adv_o = cmd_w.amwr;
  assign io_rd_o      = cmd_w.iord;
  assign io_wr_o      = cmd_w.iowr;
  assign io_wr_adv_o  = cmd_w.aiowr;
  assign int_ack_o    = cmd_w.inta;

endmodule

// File: rtl/bcmd_gen_chk.sv
module bcmd_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] stat_i,
  input logic       rdy_i,
  input logic       bus_off_i,
  input logic       cmd_ena_i,
  input logic       sys_bus_i,
  input logic       ale_o,
  input logic       den_o,
  input logic       dir_tx_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       mem_wr_adv_o,
  input logic       io_rd_o,
  input logic       io_wr_o,
  input logic       io_wr_adv_o,
  input logic       int_ack_o,
  input logic       mce_pden_o,
  input logic       cyc_start_w
);

  logic any_cmd;
  assign any_cmd = mem_rd_o | mem_wr_o | mem_wr_adv_o | io_rd_o | io_wr_o | io_wr_adv_o | int_ack_o;

  // R2: the address strobe never lasts two clocks
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o);

  // R2: a detected start is followed by the address strobe
  p_start_gives_ale_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_w |=> ale_o);

  // R3: halt after passive raises no address strobe
  p_halt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_i == 3'b011 && !ale_o && !den_o && dir_tx_o && $past(stat_i) == 3'b111 && !any_cmd) |=> !ale_o);

  // R4: a read command implies the transceivers are enabled and inbound
  p_read_has_den_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || io_rd_o) |-> (den_o && !dir_tx_o));

  // R5: normal write only while the early write is active
  p_wr_after_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o |-> mem_wr_adv_o) and (io_wr_o |-> io_wr_adv_o));

  // R5: normal write never rises in the same clock as the early write
  p_wr_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_o) |-> $past(mem_wr_adv_o));

  // R6: a late-phase command with ready low is held
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && !rdy_i && !bus_off_i && cmd_ena_i) |=> mem_wr_o || bus_off_i || !cmd_ena_i);

  // R8: at most one command strobe at a time
  p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_o, mem_wr_adv_o, io_rd_o, io_wr_adv_o, int_ack_o}));

  // R9: in peripheral mode the pin follows the transceiver enable
  p_pden_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_bus_i |-> (mce_pden_o == den_o));

  // R10: bus released means no commands
  p_bus_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_i |-> !any_cmd);

  // R11: command enable low silences enable and commands
  p_cmd_dis_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ena_i |-> (!any_cmd && !den_o));

endmodule

bind bcmd_gen bcmd_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stat_i       (stat_i),
  .rdy_i        (rdy_i),
  .bus_off_i    (bus_off_i),
  .cmd_ena_i    (cmd_ena_i),
  .sys_bus_i    (sys_bus_i),
  .ale_o        (ale_o),
  .den_o        (den_o),
  .dir_tx_o     (dir_tx_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .mem_wr_adv_o (mem_wr_adv_o),
  .io_rd_o      (io_rd_o),
  .io_wr_o      (io_wr_o),
  .io_wr_adv_o  (io_wr_adv_o),
  .int_ack_o    (int_ack_o),
  .mce_pden_o   (mce_pden_o),
  .cyc_start_w  (cyc_start_w)
);

// File: tb/bcmd_gen_bench.sv
`timescale 1ns/1ps
module bcmd_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] stat = 3'b111;
  logic       rdy = 1'b0;
  logic       bus_off = 1'b0;
  logic       cmd_ena = 1'b1;
  logic       sys_bus = 1'b0;
  logic       ale, den, dir_tx, mrd, mwr, amwr, iord, iowr, aiowr, inta, mce;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcmd_gen u_bcmd_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .stat_i       (stat),
    .rdy_i        (rdy),
    .bus_off_i    (bus_off),
    .cmd_ena_i    (cmd_ena),
    .sys_bus_i    (sys_bus),
    .ale_o        (ale),
    .den_o        (den),
    .dir_tx_o     (dir_tx),
    .mem_rd_o     (mrd),
    .mem_wr_o     (mwr),
    .mem_wr_adv_o (amwr),
    .io_rd_o      (iord),
    .io_wr_o      (iowr),
    .io_wr_adv_o  (aiowr),
    .int_ack_o    (inta),
    .mce_pden_o   (mce)
  );

  // phases: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4
  // word: {ale, den, dir_tx, mrd, mwr, amwr, iord, iowr, aiowr, inta, mce}
  function automatic logic [10:0] expect_word(logic [2:0] code, int ph);
    logic cyc, win, late, ok, inb, d;
    logic [10:0] w;
    cyc  = (ph != 0);
    win  = (ph == 2) || (ph == 3) || (ph == 4);
    late = (ph == 3) || (ph == 4);
    ok   = cmd_ena && !bus_off;
    inb  = (code == 3'b000) || (code == 3'b001) || (code == 3'b100) || (code == 3'b101);
    d    = win && cmd_ena;
    w[10] = (ph == 1);
    w[9]  = d;
    w[8]  = !(cyc && inb);
    w[7]  = win && ok && (code == 3'b100 || code == 3'b101);
    w[6]  = late && ok && (code == 3'b110);
    w[5]  = win && ok && (code == 3'b110);
    w[4]  = win && ok && (code == 3'b001);
    w[3]  = late && ok && (code == 3'b010);
    w[2]  = win && ok && (code == 3'b010);
    w[1]  = win && ok && (code == 3'b000);
    w[0]  = sys_bus ? d : ((ph == 1) && (code == 3'b000));
    return w;
  endfunction

  task automatic check_word(string tag, logic [10:0] exp);
    logic [10:0] act;
    act = {ale, den, dir_tx, mrd, mwr, amwr, iord, iowr, aiowr, inta, mce};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // one bus cycle; chained means T1 has just begun
  task automatic run_cycle(string tag, logic [2:0] code, int waits, bit chained, logic [2:0] next_code);
    int n;
    if (!chained) begin
      @(negedge clk); stat = 3'b111; rdy = 1'b0;
      tick();
      @(negedge clk); stat = code;
      tick();
    end
    check_word({tag, " R2 T1"}, expect_word(code, 1));
    @(negedge clk); rdy = 1'b0;
    tick();
    check_word({tag, " T2"}, expect_word(code, 2));
    @(negedge clk); stat = 3'b111;
    tick();
    check_word({tag, " R7 T3"}, expect_word(code, 3));
    n = waits;
    forever begin
      @(negedge clk); rdy = (n == 0);
      tick();
      if (n == 0) begin
        check_word({tag, " R6 T4"}, expect_word(code, 5));
        break;
      end
      check_word({tag, " R6 wait"}, expect_word(code, 4));
      n--;
    end
    @(negedge clk); stat = next_code; rdy = 1'b0;
    tick();
    if (next_code == 3'b111) check_word({tag, " idle"}, expect_word(code, 0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_word("R1 in reset", expect_word(3'b111, 0));
    rst_n = 1'b1;
    tick();
    check_word("R1 after reset", expect_word(3'b111, 0));
  endtask

  task automatic t_reads();
    run_cycle("R4 mem read", 3'b101, 0, 1'b0, 3'b111);
    run_cycle("R4 fetch", 3'b100, 2, 1'b0, 3'b111);
    run_cycle("R4 io read", 3'b001, 1, 1'b0, 3'b111);
  endtask

  task automatic t_writes();
    run_cycle("R5 mem write", 3'b110, 1, 1'b0, 3'b111);
    run_cycle("R5 io write", 3'b010, 0, 1'b0, 3'b111);
  endtask

  task automatic t_pden();
    sys_bus = 1'b1;
    run_cycle("R9 pden mem read", 3'b101, 0, 1'b0, 3'b111);
    run_cycle("R9 pden io write", 3'b010, 1, 1'b0, 3'b111);
    sys_bus = 1'b0;
  endtask

  task automatic t_inta_pair();
    run_cycle("R8 R9 ack first", 3'b000, 0, 1'b0, 3'b000);
    run_cycle("R8 R12 ack second", 3'b000, 0, 1'b1, 3'b111);
  endtask

  task automatic t_halt();
    @(negedge clk); stat = 3'b111;
    tick();
    @(negedge clk); stat = 3'b011;
    for (int i = 0; i < 3; i++) begin
      tick();
      check_word("R3 halt", expect_word(3'b011, 0));
    end
  endtask

  task automatic t_bus_off();
    bus_off = 1'b1;
    run_cycle("R10 released write", 3'b110, 0, 1'b0, 3'b111);
    run_cycle("R10 released ack", 3'b000, 0, 1'b0, 3'b111);
    bus_off = 1'b0;
  endtask

  task automatic t_cmd_dis();
    cmd_ena = 1'b0;
    run_cycle("R11 disabled io read", 3'b001, 0, 1'b0, 3'b111);
    sys_bus = 1'b1;
    run_cycle("R11 disabled mem write", 3'b110, 1, 1'b0, 3'b111);
    sys_bus = 1'b0;
    cmd_ena = 1'b1;
  endtask

  task automatic t_steady();
    // status stays 101 through the whole cycle: no second cycle
    @(negedge clk); stat = 3'b111; rdy = 1'b1;
    tick();
    @(negedge clk); stat = 3'b101;
    tick();
    check_word("R2 steady T1", expect_word(3'b101, 1));
    tick();
    tick();
    tick();
    check_word("R2 steady T4", expect_word(3'b101, 5));
    for (int i = 0; i < 3; i++) begin
      tick();
      check_word("R2 steady no restart", expect_word(3'b101, 0));
    end
    @(negedge clk); stat = 3'b111; rdy = 1'b0;
  endtask

  initial begin
    t_reset();
    t_reads();
    t_writes();
    t_pden();
    t_inta_pair();
    t_halt();
    t_bus_off();
    t_cmd_dis();
    t_steady();
    tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule